// File: doc/BRIEF.md
# Eight-Channel Time-Shared First-Order Servo Filter

This block runs a first-order IIR control law (proportional-integral style) for several channels at once. The channels share one multiplier and one accumulator. A single start pulse begins a run with three phases. First the block captures one fresh sample per channel from a wide sample bus. Next it computes each channel's new output from the current sample, the previous sample, the previous output and that channel's three coefficients. Last it ages the current sample into the previous-sample slot, ready for the next run.

While the outputs are being computed, the block also fetches each channel's frequency and phase words from a small profile store. It presents them to a downstream synthesizer next to the filter outputs.

Coefficients and profile words are loaded through a narrow configuration write port. Each run lasts a fixed number of cycles, so it can be scheduled against a converter and a synthesizer that have fixed timing.

Top module: `iir_servo_core`

## Requirements
- R1: After reset, busy is low and every channel's output, frequency word and phase word reads zero.
- R2: A start pulse seen while idle raises busy on the next cycle. Busy then stays high for exactly 65 cycles: 8 cycles of sample capture, 41 of computation and 16 of sample ageing.
- R3: A start pulse that arrives while busy is ignored. It neither lengthens the run nor changes any result.
- R4: Each channel's output is y = b0·x + b1·xp + a1·yp. Here x is the new sample and xp the previous one. Coefficients are signed 18-bit with 16 fraction bits. The sum is rounded by adding 2^15 and shifting right arithmetically by 16.
- R5: The rounded result is saturated to the signed 16-bit range [-32768, 32767].
- R6: At the end of a run, each channel's previous-sample slot holds the sample captured in that run.
- R7: Each channel's stored output feeds back as yp in the next run.
- R8: During a run, each channel's frequency and phase outputs are refreshed from the profile store. A profile write made while idle leaves these outputs unchanged until the next run.
- R9: While the block is idle, the output, frequency and phase ports hold their values.
- R10: A configuration write stores cfg_data into channel cfg_ch. cfg_sel selects the target: 0 writes b0 (low 18 bits), 1 writes b1, 2 writes a1, 3 writes the frequency word (32 bits) and 4 writes the phase word (low 16 bits).
- R11: Channel i takes its sample from adc_data[16i+15:16i] and reports its output on y_out[16i+15:16i]. Its frequency word appears on ftw_out[32i+31:32i] and its phase word on pow_out[16i+15:16i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| adc_data | input | 128 | One signed 16-bit sample per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_sel | input | 3 | Target selector of the write |
| cfg_data | input | 32 | Write data |
| busy | output | 1 | High from the cycle after start until ageing ends |
| y_out | output | 128 | Filter output per channel |
| ftw_out | output | 256 | Frequency word per channel |
| pow_out | output | 128 | Phase word per channel |

## Verification
The bench builds the block with its default parameters: eight channels, 16-bit samples, 18-bit coefficients with 16 fraction bits, and a 48-bit accumulator. With eight channels, per-channel mistakes in channel indexing and bus slicing show up. The 16-bit fraction makes half-way rounding of both positive and negative values visible from small odd inputs at a coefficient of one half. A coefficient near two pushes results into saturation in both directions. A unit feedback coefficient turns each channel into an integrator that climbs into saturation over a few runs.

// File: rtl/iir_pkg.sv
// Shared definitions for the time-shared servo filter.
// Assumes: the phase budget constants below describe one run.
package iir_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LOAD  = 2'd1,
        SEQ_PROC  = 2'd2,
        SEQ_SHIFT = 2'd3
    } seq_state_e;

    // Configuration target codes
    localparam logic [2:0] CFG_B0  = 3'd0;
    localparam logic [2:0] CFG_B1  = 3'd1;
    localparam logic [2:0] CFG_A1  = 3'd2;
    localparam logic [2:0] CFG_FTW = 3'd3;
    localparam logic [2:0] CFG_POW = 3'd4;

    // Computation budget: slots per channel, drain cycles, trailing cycle
    localparam int STEPS_PER_CH = 4;
    localparam int DRAIN_CYC    = 8;
    localparam int TAIL_CYC     = 1;

endpackage

// File: rtl/iir_sequencer.sv
// Phase sequencer: idle -> capture -> compute -> ageing -> idle.
// Each phase has a fixed cycle budget. The counter restarts at every phase.
// Assumes: start is ignored outside the idle phase.
module iir_sequencer
    import iir_pkg::*;
#(
    parameter int CH        = 8,
    localparam int PROC_CYC  = CH * STEPS_PER_CH + DRAIN_CYC + TAIL_CYC,
    localparam int SHIFT_CYC = 2 * CH,
    localparam int CNT_W     = $clog2(PROC_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output seq_state_e       state,
    output logic [CNT_W-1:0] cnt
);

    // Advance the phase and its cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    cnt <= '0;
                    if (start) state <= SEQ_LOAD;
                end
                SEQ_LOAD: begin
                    if (cnt == CNT_W'(CH - 1)) begin
                        state <= SEQ_PROC;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                SEQ_PROC: begin
                    if (cnt == CNT_W'(PROC_CYC - 1)) begin
                        state <= SEQ_SHIFT;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                SEQ_SHIFT: begin
                    if (cnt == CNT_W'(SHIFT_CYC - 1)) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/iir_regfile.sv
// Small per-channel store with one write port and one combinational read port.
// Assumes: indices are below DEPTH; contents clear on reset.
module iir_regfile #(
    parameter int  DEPTH = 8,
    parameter int  W     = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] mem [DEPTH];

    // Clear on reset, otherwise accept one write per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Combinational read
    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/iir_mac.sv
// Shared multiply-accumulate. Stage 1 registers the product. Stage 2 starts
// or extends the sum, and on the last term rounds, saturates and emits a
// result tagged with its channel.
// Assumes: the first and last flags frame each group of issued terms.
module iir_mac #(
    parameter int  A_W   = 16,
    parameter int  B_W   = 18,
    parameter int  ACC_W = 48,
    parameter int  FRAC  = 16,
    parameter int  OUT_W = 16,
    parameter int  TAG_W = 3,
    localparam int P_W   = A_W + B_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_vld,
    input  logic                    issue_first,
    input  logic                    issue_last,
    input  logic [TAG_W-1:0]        issue_tag,
    input  logic signed [A_W-1:0]   op_a,
    input  logic signed [B_W-1:0]   op_b,
    output logic                    res_vld,
    output logic [TAG_W-1:0]        res_tag,
    output logic signed [OUT_W-1:0] res
);

    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] O_MAX = (ACC_W'(1) <<< (OUT_W - 1)) - 1;
    localparam logic signed [ACC_W-1:0] O_MIN = -(ACC_W'(1) <<< (OUT_W - 1));

    logic signed [P_W-1:0]   prod_q;
    logic                    vld1, first1, last1;
    logic [TAG_W-1:0]        tag1;
    logic signed [ACC_W-1:0] acc_q, acc_next, rounded;

    // Stage 1: register the product and its framing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            vld1   <= 1'b0;
            first1 <= 1'b0;
            last1  <= 1'b0;
            tag1   <= '0;
        end else begin
            prod_q <= op_a * op_b;
            vld1   <= issue_vld;
            first1 <= issue_first;
            last1  <= issue_last;
            tag1   <= issue_tag;
        end
    end

    // Next accumulator value and its rounded form
    always_comb begin
        acc_next = first1 ? ACC_W'(prod_q) : acc_q + ACC_W'(prod_q);
        rounded  = (acc_next + HALF) >>> FRAC;
    end

    // Stage 2: accumulate, then round and saturate on the last term
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            res_vld <= 1'b0;
            res_tag <= '0;
            res     <= '0;
        end else begin
            res_vld <= vld1 && last1;
            if (vld1) begin
                acc_q <= acc_next;
                if (last1) begin
                    res_tag <= tag1;
                    if (rounded > O_MAX)      res <= O_MAX[OUT_W-1:0];
                    else if (rounded < O_MIN) res <= O_MIN[OUT_W-1:0];
                    else                      res <= rounded[OUT_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/iir_servo_core.sv
// Time-shared first-order servo filter over CH channels. Each run captures
// one sample per channel, computes y = b0*x + b1*xp + a1*yp through one
// shared multiplier (four slots per channel, the fourth fetching profile
// words), then copies x into xp.
// Assumes: CH is a power of two; CFG_W >= FTW_W and >= COEF_W.
module iir_servo_core
    import iir_pkg::*;
#(
    parameter int  CH        = 8,
    parameter int  SAMPLE_W  = 16,
    parameter int  COEF_W    = 18,
    parameter int  COEF_FRAC = 16,
    parameter int  ACC_W     = 48,
    parameter int  FTW_W     = 32,
    parameter int  POW_W     = 16,
    parameter int  CFG_W     = 32,
    localparam int CH_W      = (CH > 1) ? $clog2(CH) : 1,
    localparam int PROC_CYC  = CH * STEPS_PER_CH + DRAIN_CYC + TAIL_CYC,
    localparam int CNT_W     = $clog2(PROC_CYC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CH*SAMPLE_W-1:0] adc_data,
    input  logic                   cfg_we,
    input  logic [CH_W-1:0]        cfg_ch,
    input  logic [2:0]             cfg_sel,
    input  logic [CFG_W-1:0]       cfg_data,
    output logic                   busy,
    output logic [CH*SAMPLE_W-1:0] y_out,
    output logic [CH*FTW_W-1:0]    ftw_out,
    output logic [CH*POW_W-1:0]    pow_out
);

    seq_state_e           state;
    logic [CNT_W-1:0]     cnt;
    logic                 proc_slot;
    logic [1:0]           step;
    logic [CH_W-1:0]      proc_ch, shift_ch, load_ch, x0_rd_idx;
    logic [SAMPLE_W-1:0]  x0_rd, x1_rd;
    logic [COEF_W-1:0]    b0_rd, b1_rd, a1_rd;
    logic [FTW_W-1:0]     ftw_rd;
    logic [POW_W-1:0]     pow_rd;
    logic signed [SAMPLE_W-1:0] op_a, mac_res;
    logic signed [COEF_W-1:0]   op_b;
    logic                 mac_vld;
    logic [CH_W-1:0]      mac_tag;
    logic [SAMPLE_W-1:0]  adc_s [CH];
    logic [SAMPLE_W-1:0]  y_q   [CH];
    logic [FTW_W-1:0]     ftw_q [CH];
    logic [POW_W-1:0]     pow_q [CH];

    iir_sequencer #(.CH(CH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .state(state), .cnt(cnt)
    );

    // Decode the phase counter into channel and slot
    always_comb begin
        proc_slot = (state == SEQ_PROC) && (cnt < CNT_W'(CH * STEPS_PER_CH));
        step      = cnt[1:0];
        proc_ch   = CH_W'(cnt >> 2);
        shift_ch  = CH_W'(cnt >> 1);
        load_ch   = CH_W'(cnt);
        x0_rd_idx = (state == SEQ_SHIFT) ? shift_ch : proc_ch;
        busy      = (state != SEQ_IDLE);
    end

    // Per-channel slicing of the wide ports
    for (genvar g = 0; g < CH; g++) begin : g_lane
        assign adc_s[g] = adc_data[g*SAMPLE_W +: SAMPLE_W];
        assign y_out[g*SAMPLE_W +: SAMPLE_W] = y_q[g];
        assign ftw_out[g*FTW_W +: FTW_W]     = ftw_q[g];
        assign pow_out[g*POW_W +: POW_W]     = pow_q[g];
    end

    iir_regfile #(.DEPTH(CH), .W(SAMPLE_W)) u_x0 (
        .clk(clk), .rst_n(rst_n), .we(state == SEQ_LOAD), .wr_idx(load_ch),
        .wr_data(adc_s[load_ch]), .rd_idx(x0_rd_idx), .rd_data(x0_rd)
    );
    iir_regfile #(.DEPTH(CH), .W(SAMPLE_W)) u_x1 (
        .clk(clk), .rst_n(rst_n), .we((state == SEQ_SHIFT) && cnt[0]),
        .wr_idx(shift_ch), .wr_data(x0_rd), .rd_idx(proc_ch), .rd_data(x1_rd)
    );
    iir_regfile #(.DEPTH(CH), .W(COEF_W)) u_b0 (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_sel == CFG_B0), .wr_idx(cfg_ch),
        .wr_data(cfg_data[COEF_W-1:0]), .rd_idx(proc_ch), .rd_data(b0_rd)
    );
    iir_regfile #(.DEPTH(CH), .W(COEF_W)) u_b1 (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_sel == CFG_B1), .wr_idx(cfg_ch),
        .wr_data(cfg_data[COEF_W-1:0]), .rd_idx(proc_ch), .rd_data(b1_rd)
    );
    iir_regfile #(.DEPTH(CH), .W(COEF_W)) u_a1 (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_sel == CFG_A1), .wr_idx(cfg_ch),
        .wr_data(cfg_data[COEF_W-1:0]), .rd_idx(proc_ch), .rd_data(a1_rd)
    );
    iir_regfile #(.DEPTH(CH), .W(FTW_W)) u_ftw (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_sel == CFG_FTW), .wr_idx(cfg_ch),
        .wr_data(cfg_data[FTW_W-1:0]), .rd_idx(proc_ch), .rd_data(ftw_rd)
    );
    iir_regfile #(.DEPTH(CH), .W(POW_W)) u_pow (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_sel == CFG_POW), .wr_idx(cfg_ch),
        .wr_data(cfg_data[POW_W-1:0]), .rd_idx(proc_ch), .rd_data(pow_rd)
    );

    // Operand selection for the shared multiplier by slot
    always_comb begin
        unique case (step)
            2'd0:    begin op_a = x0_rd;        op_b = b0_rd; end
            2'd1:    begin op_a = x1_rd;        op_b = b1_rd; end
            default: begin op_a = y_q[proc_ch]; op_b = a1_rd; end
        endcase
    end

    iir_mac #(
        .A_W(SAMPLE_W), .B_W(COEF_W), .ACC_W(ACC_W), .FRAC(COEF_FRAC),
        .OUT_W(SAMPLE_W), .TAG_W(CH_W)
    ) u_mac (
        .clk(clk), .rst_n(rst_n),
        .issue_vld(proc_slot && step != 2'd3), .issue_first(step == 2'd0),
        .issue_last(step == 2'd2), .issue_tag(proc_ch),
        .op_a(op_a), .op_b(op_b),
        .res_vld(mac_vld), .res_tag(mac_tag), .res(mac_res)
    );

    // Output store: filter results (also the feedback term) and profile words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CH; i++) begin
                y_q[i]   <= '0;
                ftw_q[i] <= '0;
                pow_q[i] <= '0;
            end
        end else begin
            if (mac_vld) y_q[mac_tag] <= mac_res;
            if (proc_slot && step == 2'd3) begin
                ftw_q[proc_ch] <= ftw_rd;
                pow_q[proc_ch] <= pow_rd;
            end
        end
    end

endmodule

// File: rtl/iir_servo_checker.sv
// Port-level temporal checks for iir_servo_core, bound to every instance.
// Assumes: the run length equals capture + compute + ageing budgets.
module iir_servo_checker
    import iir_pkg::*;
#(
    parameter int  CH       = 8,
    parameter int  SAMPLE_W = 16,
    parameter int  FTW_W    = 32,
    parameter int  POW_W    = 16,
    localparam int RUN_CYC  = CH + (CH * STEPS_PER_CH + DRAIN_CYC + TAIL_CYC) + 2 * CH,
    localparam int RC_W     = $clog2(RUN_CYC + 2)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic [CH*SAMPLE_W-1:0] y_out,
    input logic [CH*FTW_W-1:0]    ftw_out,
    input logic [CH*POW_W-1:0]    pow_out
);

    logic [RC_W-1:0] run_cnt;

    // Count cycles spent busy in the current run
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_cnt <= '0;
        else                 run_cnt <= run_cnt + 1'b1;
    end

    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == RC_W'(RUN_CYC)));

    assert_restart_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && run_cnt < RC_W'(RUN_CYC - 1)) |=> busy);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(y_out) && $stable(ftw_out) && $stable(pow_out)));

endmodule

bind iir_servo_core iir_servo_checker #(
    .CH(CH), .SAMPLE_W(SAMPLE_W), .FTW_W(FTW_W), .POW_W(POW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .y_out(y_out), .ftw_out(ftw_out), .pow_out(pow_out)
);

// File: tb/sim_iir_servo_core.sv
// Scoreboard bench: the driver models each run and queues expected
// per-channel results; the monitor compares them when busy falls.
module sim_iir_servo_core;

    localparam int CH = 8;
    localparam int RUN_LEN = 65;

    typedef struct {
        int     ch;
        int     y;
        longint ftw;
        int     pw;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [127:0]  adc_data = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_ch = '0;
    logic [2:0]    cfg_sel = '0;
    logic [31:0]   cfg_data = '0;
    logic          busy;
    logic [127:0]  y_out;
    logic [255:0]  ftw_out;
    logic [127:0]  pow_out;

    int     checks = 0;
    int     errors = 0;
    int     runs_done = 0;
    int     busy_len = 0;
    logic   busy_prev = 1'b0;
    exp_t   sb [$];

    // Model state
    longint m_b0 [CH], m_b1 [CH], m_a1 [CH], m_ftw [CH];
    int     m_pow [CH], m_x1 [CH], m_y1 [CH], smp [CH];

    iir_servo_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_data(adc_data),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .busy(busy), .y_out(y_out), .ftw_out(ftw_out), .pow_out(pow_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int filt(input longint acc);
        longint r = (acc + 64'sd32768) >>> 16;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    task automatic cfg_write(input int ch, input int sel, input longint val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 3'(sel); cfg_data = 32'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_b0[ch] = val;
            1: m_b1[ch] = val;
            2: m_a1[ch] = val;
            3: m_ftw[ch] = val & 64'hFFFF_FFFF;
            default: m_pow[ch] = int'(val & 64'hFFFF);
        endcase
    endtask

    task automatic set_coefs(input int ch, input longint b0, input longint b1, input longint a1);
        cfg_write(ch, 0, b0);
        cfg_write(ch, 1, b1);
        cfg_write(ch, 2, a1);
    endtask

    // Driver: model one run, queue expectations, pulse start, await result
    task automatic run_servo(input bit extra_start);
        int target = runs_done + 1;
        for (int i = 0; i < CH; i++) begin
            exp_t e;
            e.ch  = i;
            e.y   = filt(m_b0[i] * smp[i] + m_b1[i] * m_x1[i] + m_a1[i] * m_y1[i]);
            e.ftw = m_ftw[i];
            e.pw  = m_pow[i];
            sb.push_back(e);
            m_x1[i] = smp[i];
            m_y1[i] = e.y;
            adc_data[i*16 +: 16] = 16'(smp[i]);
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            repeat (20) @(negedge clk);
            adc_data = {8{16'h7ABC}};
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (runs_done == target);
        @(negedge clk);
    endtask

    // Monitor: time each run and compare queued items when busy falls
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_len++;
            if (busy_prev && !busy) begin
                check(busy_len == RUN_LEN, "R2 run length", busy_len, RUN_LEN);
                for (int i = 0; i < CH; i++) begin
                    exp_t e;
                    e = sb.pop_front();
                    check($signed(y_out[e.ch*16 +: 16]) == e.y, "R4/R5/R6/R7/R11 y_out",
                          $signed(y_out[e.ch*16 +: 16]), e.y);
                    check(ftw_out[e.ch*32 +: 32] == e.ftw, "R8/R10 ftw_out",
                          ftw_out[e.ch*32 +: 32], e.ftw);
                    check(pow_out[e.ch*16 +: 16] == e.pw, "R8/R10 pow_out",
                          pow_out[e.ch*16 +: 16], e.pw);
                end
                busy_len = 0;
                runs_done++;
            end
            busy_prev = busy;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", runs_done, -1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] y_hold;
        for (int i = 0; i < CH; i++) begin
            m_b0[i] = 0; m_b1[i] = 0; m_a1[i] = 0; m_ftw[i] = 0;
            m_pow[i] = 0; m_x1[i] = 0; m_y1[i] = 0; smp[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(y_out == '0, "R1 y_out", y_out != '0, 0);
        check(ftw_out == '0 && pow_out == '0, "R1 profile", ftw_out != '0, 0);

        // R10 R11: unity b0 passes samples through; distinct profile words
        for (int i = 0; i < CH; i++) begin
            set_coefs(i, 65536, 0, 0);
            cfg_write(i, 3, 64'h1000_0000 * i + 5);
            cfg_write(i, 4, 100 * i + 1);
            smp[i] = 1000 * i - 3500;
        end
        run_servo(1'b0);

        // R4 R6 R7: mixed coefficients; odd channels echo the previous sample
        for (int i = 0; i < CH; i++) begin
            if (i % 2 == 0) set_coefs(i, 32768, -16384, 49152);
            else            set_coefs(i, 0, 65536, 0);
            smp[i] = -777 * i + 1234;
        end
        run_servo(1'b0);
        for (int i = 0; i < CH; i++) smp[i] = 2500 - 611 * i;
        run_servo(1'b0);

        // R4 rounding: half coefficient on odd samples of both signs
        for (int i = 0; i < CH; i++) begin
            set_coefs(i, 32768, 0, 0);
            smp[i] = (i % 2 == 0) ? (2 * i + 1) : -(2 * i + 1);
        end
        run_servo(1'b0);

        // R5: near-two gain saturates high and low
        for (int i = 0; i < CH; i++) begin
            set_coefs(i, 130000, 0, 0);
            smp[i] = (i % 2 == 0) ? 30000 : -30000;
        end
        run_servo(1'b0);

        // R7 R5: integrators climb into saturation over several runs
        for (int i = 0; i < CH; i++) begin
            set_coefs(i, 65536, 0, 65536);
            smp[i] = (i % 2 == 0) ? 12000 : -9000;
        end
        for (int r = 0; r < 4; r++) run_servo(1'b0);

        // R3: second start mid-run with a changed bus is ignored
        for (int i = 0; i < CH; i++) begin
            set_coefs(i, 16384, 32768, 0);
            smp[i] = 300 * i - 1000;
        end
        run_servo(1'b1);

        // R8 R9: profile write while idle leaves outputs alone until a run
        y_hold = y_out;
        cfg_write(2, 3, 64'hDEAD_BEEF);
        cfg_write(5, 4, 64'h0000_4321);
        repeat (3) @(negedge clk);
        check(ftw_out[2*32 +: 32] == 32'h2000_0005, "R8 ftw held while idle",
              ftw_out[2*32 +: 32], 32'h2000_0005);
        check(pow_out[5*16 +: 16] == 16'd501, "R8 pow held while idle",
              pow_out[5*16 +: 16], 501);
        check(y_out == y_hold, "R9 y_out held while idle", y_out != y_hold, 0);
        run_servo(1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule